// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill Traps

This block is a register file for a load/store processor core in which procedure calls do not push arguments to a memory stack. Software addresses 32 registers through a 5-bit index. The physical storage is larger: a group of globals, and a ring of windows that each hold private registers. A window pointer picks the live window. Every index is translated through this pointer before storage is read or written.

A call steps the pointer forward and a return steps it back, in both cases modulo the window count. The window reached by a call shares eight registers with the window that made the call. Values the caller places in its outgoing registers therefore appear in the callee's incoming registers without any copy.

The ring can only hold a limited number of live activations. When a call finds the ring full, the block raises an overflow trap and stalls the call. An outside agent then moves the oldest window to memory and reports with a completion pulse. When a return finds that its caller's window is no longer held in the ring, the block raises an underflow trap in the same way and waits for the window to be brought back. The memory transfer itself is not part of this block.

Top module: `regwin_file`

## Requirements
- R1: Indices 0 to 7 name eight global registers. These are the same physical registers in every window.
- R2: Index 0 always reads as zero, and a write to index 0 has no effect.
- R3: Indices 16 to 23 are locals private to the current window. Indices 24 to 31 are the window's ins. Indices 8 to 15 are its outs, which are the same storage as the ins of the next window up (pointer + 1 mod NWIN). So a value written to out k before a save reads back at in k (index 24+k) after the save.
- R4: Both read ports are combinational from the current pointer. A write lands on the rising clock edge. A write in the same cycle as a save or restore is translated through the pointer as it was before that edge.
- R5: After reset the pointer is 0. An accepted save moves it to pointer+1 mod NWIN, and an accepted restore moves it to pointer−1 mod NWIN. When save and restore arrive together, only the save acts.
- R6: After reset, no window below the current one is resident. Each accepted save adds one resident window, up to a limit of NWIN−2. A save at that limit leaves the pointer unchanged and raises the overflow trap from the next cycle. While that trap is up, trap_win shows (pointer+2) mod NWIN, which is the oldest window to spill.
- R7: A restore when no window below the current one is resident leaves the pointer unchanged and raises the underflow trap from the next cycle. While that trap is up, trap_win shows (pointer−1) mod NWIN, which is the window to fill. trap_win is 0 when no trap is up.
- R8: While either trap is up, the pointer holds and the trap stays up. Save and restore requests are ignored during this time.
- R9: A spill-done pulse while the overflow trap is up finishes the stalled save on that edge: the pointer advances, the trap clears, and the resident count is unchanged overall. A fill-done pulse does the same for a stalled restore. A completion pulse that does not match the pending trap is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 5 | Read port A register index |
| ra_data | output | DW | Read port A data |
| rb_idx | input | 5 | Read port B register index |
| rb_data | output | DW | Read port B data |
| we | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Save pulse: move to a new window |
| restore_req | input | 1 | Restore pulse: return to the previous window |
| spill_done | input | 1 | Oldest window has been stored to memory |
| fill_done | input | 1 | Caller window has been reloaded from memory |
| cwp | output | log2(NWIN) | Current window pointer |
| ovf_trap | output | 1 | Overflow: spill request |
| unf_trap | output | 1 | Underflow: fill request |
| trap_win | output | log2(NWIN) | Window the pending trap concerns |

## Verification
A pointer that is off by one shows at the read ports the next time any windowed index is read. A wrong overlap shows the first time an out written before a save is read as an in after it. A resident count that has drifted stays hidden until the ring fills or empties: a trap then comes a call early or late, or is missed completely. For that reason the stimulus drives the call depth against both limits many times, and every cycle the pointer, both trap lines, trap_win and both read ports are compared with a separate model.

// File: rtl/regwin_file.sv
`timescale 1ns/1ps
module regwin_file #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               ra_idx,
  output logic [DW-1:0]            ra_data,
  input  logic [4:0]               rb_idx,
  output logic [DW-1:0]            rb_data,
  input  logic                     we,
  input  logic [4:0]               wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic                     save_req,
  input  logic                     restore_req,
  input  logic                     spill_done,
  input  logic                     fill_done,
  output logic [$clog2(NWIN)-1:0]  cwp,
  output logic                     ovf_trap,
  output logic                     unf_trap,
  output logic [$clog2(NWIN)-1:0]  trap_win
);
  localparam int CW    = $clog2(NWIN);
  localparam int NPHYS = 8 + NWIN * 16;
  localparam int PW    = $clog2(NPHYS);
  localparam int MAXR  = NWIN - 2;

  typedef enum logic [1:0] {P_IDLE, P_SPILL, P_FILL} pend_t;

  logic [DW-1:0] rf [NPHYS];
  logic [CW-1:0] cwp_q;
  logic [CW-1:0] rcnt_q;
  pend_t         pend_q;

  function automatic logic [CW-1:0] wnext(input logic [CW-1:0] w);
    return (w == CW'(NWIN - 1)) ? '0 : w + 1'b1;
  endfunction

  function automatic logic [CW-1:0] wprev(input logic [CW-1:0] w);
    return (w == '0) ? CW'(NWIN - 1) : w - 1'b1;
  endfunction

  function automatic logic [PW-1:0] xlate(input logic [4:0] idx, input logic [CW-1:0] w);
    case (idx[4:3])
      2'd0:    return PW'(idx);
      2'd1:    return PW'(8 + 16 * int'(wnext(w)) + int'(idx[2:0]));
      2'd2:    return PW'(16 + 16 * int'(w) + int'(idx[2:0]));
      default: return PW'(8 + 16 * int'(w) + int'(idx[2:0]));
    endcase
  endfunction

  assign ra_data  = rf[xlate(ra_idx, cwp_q)];
  assign rb_data  = rf[xlate(rb_idx, cwp_q)];
  assign cwp      = cwp_q;
  assign ovf_trap = (pend_q == P_SPILL);
  assign unf_trap = (pend_q == P_FILL);
  assign trap_win = ovf_trap ? wnext(wnext(cwp_q)) : (unf_trap ? wprev(cwp_q) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) rf[i] <= '0;
    end else if (we && wr_idx != 5'd0) begin
      rf[xlate(wr_idx, cwp_q)] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q  <= '0;
      rcnt_q <= '0;
      pend_q <= P_IDLE;
    end else begin
      case (pend_q)
        P_IDLE: begin
          if (save_req) begin
            if (rcnt_q == CW'(MAXR)) pend_q <= P_SPILL;
            else begin
              cwp_q  <= wnext(cwp_q);
              rcnt_q <= rcnt_q + 1'b1;
            end
          end else if (restore_req) begin
            if (rcnt_q == '0) pend_q <= P_FILL;
            else begin
              cwp_q  <= wprev(cwp_q);
              rcnt_q <= rcnt_q - 1'b1;
            end
          end
        end
        P_SPILL: if (spill_done) begin
          cwp_q  <= wnext(cwp_q);
          pend_q <= P_IDLE;
        end
        P_FILL: if (fill_done) begin
          cwp_q  <= wprev(cwp_q);
          pend_q <= P_IDLE;
        end
        default: pend_q <= P_IDLE;
      endcase
    end
  end

  // R2
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n) rf[0] == '0);

  // R5
  save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_trap && !unf_trap && save_req && rcnt_q != CW'(MAXR)) |=> (cwp == wnext($past(cwp))));

  // R6
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_trap && !unf_trap && save_req && rcnt_q == CW'(MAXR)) |=> (ovf_trap && $stable(cwp)));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rcnt_q <= CW'(MAXR));

  // R7
  unf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_trap && !unf_trap && !save_req && restore_req && rcnt_q == '0) |=> (unf_trap && $stable(cwp)));

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_trap && !spill_done) || (unf_trap && !fill_done)) |=> ($stable(cwp) && $stable({ovf_trap, unf_trap})));

  // R9
  spill_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap && spill_done) |=> (!ovf_trap && cwp == wnext($past(cwp))));

  // R9
  fill_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_trap && fill_done) |=> (!unf_trap && cwp == wprev($past(cwp))));
endmodule

// File: tb/regwin_file_bench.sv
`timescale 1ns/1ps
module regwin_file_bench;
  localparam int NW = 8;

  logic clk = 0, rst_n = 0;
  logic [4:0] ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [31:0] ra_data, rb_data, wr_data = 0;
  logic we = 0, save_req = 0, restore_req = 0, spill_done = 0, fill_done = 0;
  logic [2:0] cwp, trap_win;
  logic ovf_trap, unf_trap;

  regwin_file u_regwin_file (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [31:0] m_glob [8];
  logic [31:0] m_ins  [NW][8];
  logic [31:0] m_loc  [NW][8];
  int m_cwp, m_rcnt, m_pend;

  function automatic int nx(int w); return (w + 1) % NW; endfunction
  function automatic int pv(int w); return (w + NW - 1) % NW; endfunction

  function automatic logic [31:0] mread(int idx, int w);
    if (idx == 0) return 0;
    if (idx < 8) return m_glob[idx];
    if (idx < 16) return m_ins[nx(w)][idx-8];
    if (idx < 24) return m_loc[w][idx-16];
    return m_ins[w][idx-24];
  endfunction

  task automatic mwrite(int idx, int w, logic [31:0] d);
    if (idx == 0) return;
    if (idx < 8) m_glob[idx] = d;
    else if (idx < 16) m_ins[nx(w)][idx-8] = d;
    else if (idx < 24) m_loc[w][idx-16] = d;
    else m_ins[w][idx-24] = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; we = 0; save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
    for (int i = 0; i < 8; i++) m_glob[i] = 0;
    for (int w = 0; w < NW; w++) for (int i = 0; i < 8; i++) begin m_ins[w][i] = 0; m_loc[w][i] = 0; end
    m_cwp = 0; m_rcnt = 0; m_pend = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic cyc(bit w, int wi, logic [31:0] wd, int a, int b, bit sv, bit rs, bit sp, bit fl);
    @(negedge clk);
    we = w; wr_idx = 5'(wi); wr_data = wd; ra_idx = 5'(a); rb_idx = 5'(b);
    save_req = sv; restore_req = rs; spill_done = sp; fill_done = fl;
    #1;
    check("R4", ra_data, mread(a, m_cwp));
    check("R4", rb_data, mread(b, m_cwp));
    check("R5", 32'(cwp), 32'(m_cwp));
    check("R6", 32'(ovf_trap), 32'(m_pend == 1));
    check("R7", 32'(unf_trap), 32'(m_pend == 2));
    check("R6", 32'(trap_win), m_pend == 1 ? 32'((m_cwp + 2) % NW) : (m_pend == 2 ? 32'(pv(m_cwp)) : 0));
    @(posedge clk);
    if (w) mwrite(wi, m_cwp, wd);
    if (m_pend == 0) begin
      if (sv) begin
        if (m_rcnt == NW - 2) m_pend = 1; else begin m_cwp = nx(m_cwp); m_rcnt++; end
      end else if (rs) begin
        if (m_rcnt == 0) m_pend = 2; else begin m_cwp = pv(m_cwp); m_rcnt--; end
      end
    end else if (m_pend == 1 && sp) begin m_cwp = nx(m_cwp); m_pend = 0; end
    else if (m_pend == 2 && fl) begin m_cwp = pv(m_cwp); m_pend = 0; end
  endtask

  task automatic look(int a, int b);
    @(negedge clk);
    we = 0; save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
    ra_idx = 5'(a); rb_idx = 5'(b);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    look(0, 5);
    check("R5", 32'(cwp), 0);
    check("R6", 32'(ovf_trap), 0);
    check("R7", 32'(unf_trap), 0);
    check("R4", rb_data, 0);

    cyc(1, 0, 32'hDEADBEEF, 0, 0, 0, 0, 0, 0);
    look(0, 0);
    check("R2", ra_data, 0);

    cyc(1, 3, 32'h11112222, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    look(3, 0);
    check("R1", ra_data, 32'h11112222);
    check("R5", 32'(cwp), 1);

    cyc(1, 8, 32'h0000A0A0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    look(24, 8);
    check("R3", ra_data, 32'h0000A0A0);
    cyc(1, 16, 32'h00005555, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    look(16, 8);
    check("R3", ra_data, 0);
    check("R3", rb_data, 32'h0000A0A0);

    cyc(1, 9, 32'h0000C0DE, 9, 25, 1, 0, 0, 0);
    look(25, 0);
    check("R4", ra_data, 32'h0000C0DE);
    check("R5", 32'(cwp), 2);

    cyc(0, 0, 0, 0, 0, 1, 1, 0, 0);
    look(0, 0);
    check("R5", 32'(cwp), 3);

    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    look(0, 0);
    check("R6", 32'(ovf_trap), 1);
    check("R6", 32'(cwp), 6);
    check("R6", 32'(trap_win), 0);

    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    look(0, 0);
    check("R8", 32'(cwp), 6);
    check("R8", 32'(ovf_trap), 1);

    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    look(0, 0);
    check("R9", 32'(cwp), 7);
    check("R9", 32'(ovf_trap), 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
    look(0, 0);
    check("R9", 32'(ovf_trap), 1);
    check("R6", 32'(trap_win), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);

    do_reset();
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
    look(0, 0);
    check("R7", 32'(unf_trap), 1);
    check("R7", 32'(trap_win), 7);
    check("R7", 32'(cwp), 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    look(0, 0);
    check("R9", 32'(unf_trap), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    look(0, 0);
    check("R9", 32'(cwp), 7);
    check("R9", 32'(unf_trap), 0);

    for (int i = 0; i < 4000; i++) begin
      bit sp, fl;
      sp = (m_pend == 1 && ($urandom % 4) == 0) || (($urandom % 25) == 0);
      fl = (m_pend == 2 && ($urandom % 4) == 0) || (($urandom % 25) == 0);
      cyc(1'($urandom % 2), int'($urandom % 32), $urandom, int'($urandom % 32), int'($urandom % 32),
          ($urandom % 10) < 3, ($urandom % 10) < 3, sp, fl);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule